// File: doc/BRIEF.md
# Programmable Two-Wire Clock Divider

This block turns the system clock into the timing pulses that pace a two-wire serial master. Three cascaded stages do the division. A half-period counter spans 2·(THP+1) system cycles. A power-of-two prescaler then divides by 2^N. A final stage divides by M+1. The chain emits a one-cycle `tick_o` ten times per bus clock period. It also emits `scl_toggle_o` once per half bus period, which tells the bit engine when to flip the clock line. The bus clock frequency is therefore fsys / (2·(THP+1)) / 2^N / (M+1) / 10.

Software writes the high-period count through one strobe and the packed M/N control byte through another. The divider keeps the written values as pending settings. It copies them into the active settings only at the terminal count of the whole chain, so a period is never cut short and never stretched by a write. Every output is a single-cycle enable rather than a derived clock, so the whole design stays in one clock domain. While `enable` is low, all counters hold their state.

Top module: `twd_clk_div`

## Requirements
- R1: After reset, the stored settings read THP = 0x18, M = 2 and N = 0. With `enable` high, ticks then repeat every 150 system cycles.
- R2: With `enable` held high, consecutive `tick_o` pulses are exactly 2·(THP+1)·2^N·(M+1) system cycles apart, using the active settings.
- R3: A `cc_wr` strobe stores `cc_wdata[6:3]` as M and `cc_wdata[2:0]` as N.
- R4: A `thp_wr` strobe whose data is below 5 stores 5. Data of 5 or more is stored unchanged.
- R5: `tick_o` is high for a single system cycle per tick period.
- R6: `scl_toggle_o` is high only together with `tick_o`, and on every fifth tick, so one bus clock period spans ten ticks.
- R7: A write made in the middle of a tick period does not change that period. The new settings govern the period that starts at the next tick.
- R8: While `enable` is low, no tick is produced and the count is held. On resume, the count continues, so the interrupted period lasts its normal length plus the disabled cycles.
- R9: The full ranges M = 0..15 and N = 0..7 are honoured, including M = 0, N = 0 and N = 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable; counters hold while low |
| thp_wr | input | 1 | Write strobe for the high-period count |
| thp_wdata | input | 8 | High-period count write data |
| cc_wr | input | 1 | Write strobe for the M/N control byte |
| cc_wdata | input | 7 | M in bits 6:3, N in bits 2:0 |
| cfg_thp | output | 8 | Stored (pending) high-period count |
| cfg_m | output | 4 | Stored (pending) M divider |
| cfg_n | output | 3 | Stored (pending) N divider |
| tick_o | output | 1 | One-cycle pulse at ten times the bus clock rate |
| scl_toggle_o | output | 1 | One-cycle pulse marking each bus clock half period |

## Verification
Several properties are checked on every cycle:
- each stage count stays within its active limit;
- a stored THP never falls below the floor;
- the active settings change only at a tick;
- ticks last one cycle and are absent after a disabled cycle;
- the toggle never appears without a tick.

The exact tick spacing for each setting, the five-tick toggle cadence, the old period surviving a mid-period write, and the stretched period after a pause are measured by the bench. Only the bench's timed scenarios can show these.

// File: rtl/twd_pkg.sv
package twd_pkg;
   // ticks per bus clock half period (ten ticks per full bus period)
   localparam int unsigned TICKS_PER_HALF = 5;
   localparam int unsigned PHASE_W        = 3;
endpackage

// File: rtl/twd_mod_counter.sv
module twd_mod_counter #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic [W-1:0] limit,
   output logic         wrap_o
);
   logic [W-1:0] cnt;

   assign wrap_o = step && (cnt >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (wrap_o) cnt <= '0;
      else if (step)   cnt <= cnt + 1'b1;
   end

   // R2: limits only change when every stage has wrapped, so the count never exceeds them
   p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n) cnt <= limit);
   // R8: no step, no movement
   p_cnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n) !step |=> $stable(cnt));
endmodule

// File: rtl/twd_cfg_regs.sv
module twd_cfg_regs #(
   parameter int unsigned THP_W   = 8,
   parameter int unsigned M_W     = 4,
   parameter int unsigned N_W     = 3,
   parameter int unsigned THP_MIN = 5,
   parameter int unsigned THP_RST = 24,
   parameter int unsigned M_RST   = 2,
   parameter int unsigned N_RST   = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               thp_wr,
   input  logic [THP_W-1:0]   thp_wdata,
   input  logic               cc_wr,
   input  logic [M_W+N_W-1:0] cc_wdata,
   input  logic               load,
   output logic [THP_W-1:0]   thp_q,
   output logic [M_W-1:0]     m_q,
   output logic [N_W-1:0]     n_q,
   output logic [THP_W-1:0]   act_thp,
   output logic [M_W-1:0]     act_m,
   output logic [N_W-1:0]     act_n
);
   localparam logic [THP_W-1:0] FLOOR = THP_W'(THP_MIN);

   logic [THP_W-1:0] thp_clamped;
   assign thp_clamped = (thp_wdata < FLOOR) ? FLOOR : thp_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thp_q <= THP_W'(THP_RST);
         m_q   <= M_W'(M_RST);
         n_q   <= N_W'(N_RST);
      end else begin
         if (thp_wr) thp_q <= thp_clamped;
         if (cc_wr) begin
            m_q <= cc_wdata[M_W+N_W-1:N_W];
            n_q <= cc_wdata[N_W-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_thp <= THP_W'(THP_RST);
         act_m   <= M_W'(M_RST);
         act_n   <= N_W'(N_RST);
      end else if (load) begin
         act_thp <= thp_q;
         act_m   <= m_q;
         act_n   <= n_q;
      end
   end

   p_thp_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
      thp_wr |=> thp_q >= FLOOR);
   p_active_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(act_thp) && $stable(act_m) && $stable(act_n)));
endmodule

// File: rtl/twd_clk_div.sv
module twd_clk_div #(
   parameter int unsigned THP_W   = 8,
   parameter int unsigned M_W     = 4,
   parameter int unsigned N_W     = 3,
   parameter int unsigned THP_MIN = 5,
   parameter int unsigned THP_RST = 24,
   parameter int unsigned M_RST   = 2,
   parameter int unsigned N_RST   = 0,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               thp_wr,
   input  logic [THP_W-1:0]   thp_wdata,
   input  logic               cc_wr,
   input  logic [M_W+N_W-1:0] cc_wdata,
   output logic [THP_W-1:0]   cfg_thp,
   output logic [M_W-1:0]     cfg_m,
   output logic [N_W-1:0]     cfg_n,
   output logic               tick_o,
   output logic               scl_toggle_o
);
   import twd_pkg::*;

   localparam int unsigned S1_W = THP_W + 1;
   localparam int unsigned PS_W = 1 << N_W;

   if (THP_W < 3)                  begin : g_bad_thp_w $error("THP_W too small"); end
   if (N_W < 1 || N_W > 5)         begin : g_bad_n_w   $error("N_W out of range"); end
   if (THP_MIN >= (1 << THP_W))    begin : g_bad_min   $error("THP_MIN exceeds field"); end
   if (THP_RST < THP_MIN)          begin : g_bad_rst   $error("THP_RST below floor"); end

   logic [THP_W-1:0] act_thp;
   logic [M_W-1:0]   act_m;
   logic [N_W-1:0]   act_n;
   logic             half_wrap, pre_wrap, tick_c, tog_c;

   twd_cfg_regs #(
      .THP_W(THP_W), .M_W(M_W), .N_W(N_W), .THP_MIN(THP_MIN),
      .THP_RST(THP_RST), .M_RST(M_RST), .N_RST(N_RST)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .thp_wr(thp_wr), .thp_wdata(thp_wdata),
      .cc_wr(cc_wr), .cc_wdata(cc_wdata),
      .load(tick_c),
      .thp_q(cfg_thp), .m_q(cfg_m), .n_q(cfg_n),
      .act_thp(act_thp), .act_m(act_m), .act_n(act_n)
   );

   logic [S1_W-1:0]    half_limit;
   logic [PS_W-1:0]    pre_limit;
   logic [PHASE_W-1:0] phase_limit;
   assign half_limit  = {act_thp, 1'b1};               // 2*(THP+1)-1
   assign pre_limit   = PS_W'((PS_W'(1) << act_n) - 1'b1);
   assign phase_limit = PHASE_W'(TICKS_PER_HALF - 1);

   twd_mod_counter #(.W(S1_W)) u_half (
      .clk(clk), .rst_n(rst_n), .step(enable), .limit(half_limit), .wrap_o(half_wrap));
   twd_mod_counter #(.W(PS_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .step(half_wrap), .limit(pre_limit), .wrap_o(pre_wrap));
   twd_mod_counter #(.W(M_W)) u_mdiv (
      .clk(clk), .rst_n(rst_n), .step(pre_wrap), .limit(act_m), .wrap_o(tick_c));
   twd_mod_counter #(.W(PHASE_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .step(tick_c), .limit(phase_limit), .wrap_o(tog_c));

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tick_o       <= 1'b0;
            scl_toggle_o <= 1'b0;
         end else begin
            tick_o       <= tick_c;
            scl_toggle_o <= tog_c;
         end
      end
      p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n) !enable |=> !tick_o);
   end else begin : g_out_comb
      assign tick_o       = tick_c;
      assign scl_toggle_o = tog_c;
      p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n) !enable |-> !tick_o);
   end

   p_tick_single_r5: assert property (@(posedge clk) disable iff (!rst_n) tick_o |=> !tick_o);
   p_toggle_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n) scl_toggle_o |-> tick_o);
endmodule

// File: tb/twd_clk_div_bench.sv
`timescale 1ns/1ps
module twd_clk_div_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic       thp_wr = 1'b0;
   logic [7:0] thp_wdata = '0;
   logic       cc_wr = 1'b0;
   logic [6:0] cc_wdata = '0;
   logic [7:0] cfg_thp;
   logic [3:0] cfg_m;
   logic [2:0] cfg_n;
   logic       tick_o, scl_toggle_o;

   int unsigned cyc = 0;
   int unsigned n_run = 0, n_fail = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   twd_clk_div u_twd_clk_div (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .thp_wr(thp_wr), .thp_wdata(thp_wdata), .cc_wr(cc_wr), .cc_wdata(cc_wdata),
      .cfg_thp(cfg_thp), .cfg_m(cfg_m), .cfg_n(cfg_n),
      .tick_o(tick_o), .scl_toggle_o(scl_toggle_o));

   // stimulus table: THP write data, control byte {M,N}
   localparam int NV = 8;
   localparam logic [7:0] V_THP [NV] = '{8'd5, 8'd5, 8'd24, 8'd6, 8'd2, 8'd255, 8'd10, 8'd5};
   localparam logic [6:0] V_CC  [NV] = '{{4'd0,3'd0}, {4'd1,3'd1}, {4'd2,3'd0}, {4'd3,3'd2},
                                         {4'd0,3'd0}, {4'd0,3'd0}, {4'd15,3'd0}, {4'd0,3'd7}};

   function automatic int unsigned exp_period(input int unsigned thp, input int unsigned m,
                                              input int unsigned n);
      int unsigned t;
      t = (thp < 5) ? 5 : thp;
      return 2 * (t + 1) * (1 << n) * (m + 1);
   endfunction

   task automatic check(input string req, input int unsigned act, input int unsigned exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_tick(output int unsigned t);
      int unsigned guard = 0;
      @(negedge clk);
      while (!tick_o && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
      if (!tick_o) check("R2 tick timeout", 0, 1);
      t = cyc;
   endtask

   task automatic write_cfg(input logic [7:0] thp, input logic [6:0] cc);
      @(negedge clk);
      thp_wr = 1'b1; thp_wdata = thp; cc_wr = 1'b1; cc_wdata = cc;
      @(negedge clk);
      thp_wr = 1'b0; cc_wr = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int unsigned ta, tb, tc;
      repeat (3) @(negedge clk);
      // R1: reset values
      check("R1 thp", cfg_thp, 8'h18);
      check("R1 m", cfg_m, 2);
      check("R1 n", cfg_n, 0);
      check("R1 tick idle", tick_o, 0);
      rst_n = 1'b1;
      enable = 1'b1;
      wait_tick(ta);
      wait_tick(tb);
      check("R1 default period", tb - ta, 150);

      // R2 / R9 table walk; new settings apply from the tick after the write (R7)
      for (int i = 0; i < NV; i++) begin
         write_cfg(V_THP[i], V_CC[i]);
         wait_tick(ta);
         wait_tick(tb);
         check("R2 period", tb - ta,
               exp_period(V_THP[i], V_CC[i][6:3], V_CC[i][2:0]));
         check("R3 m field", cfg_m, V_CC[i][6:3]);
      end

      // R3 field positions, R4 floor
      write_cfg(8'd3, {4'd9, 3'd5});
      check("R4 thp floor", cfg_thp, 5);
      check("R3 m bits 6:3", cfg_m, 9);
      check("R3 n bits 2:0", cfg_n, 5);
      write_cfg(8'd0, 7'd0);
      check("R4 thp zero", cfg_thp, 5);
      write_cfg(8'd7, 7'd0);
      check("R4 thp kept", cfg_thp, 7);
      wait_tick(ta);                       // period 16 now active

      // R7: mid-period write keeps the running period
      wait_tick(ta);
      repeat (4) @(negedge clk);
      write_cfg(8'd5, {4'd1, 3'd0});       // new period 24
      wait_tick(tb);
      check("R7 old period kept", tb - ta, 16);
      wait_tick(tc);
      check("R7 new period", tc - tb, 24);

      // R5: tick lasts one cycle
      @(negedge clk);
      check("R5 single cycle", tick_o, 0);

      // R6: toggle coincides with tick, every fifth tick
      begin
         int unsigned cnt = 0;
         int unsigned guard = 0;
         while (!scl_toggle_o && guard < 2000) begin @(negedge clk); guard++; end
         check("R6 toggle with tick", tick_o, 1);
         for (int k = 0; k < 2; k++) begin
            cnt = 0;
            do begin
               @(negedge clk);
               if (tick_o) cnt++;
               if (scl_toggle_o && !tick_o) check("R6 toggle alone", 1, 0);
            end while (!scl_toggle_o);
            check("R6 ticks per toggle", cnt, 5);
         end
      end

      // R8: pause holds the count
      wait_tick(ta);
      repeat (2) @(negedge clk);
      enable = 1'b0;
      begin
         int unsigned seen = 0;
         for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (tick_o) seen++;
            if (k < 19) enable = 1'b0; else enable = 1'b1;
         end
         check("R8 no tick while off", seen, 0);
      end
      wait_tick(tb);
      check("R8 stretched period", tb - ta, 24 + 20);
      wait_tick(tc);
      check("R8 normal after resume", tc - tb, 24);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule